// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block is the primary control decoder of a single-cycle 32-bit load/store processor core. It is purely combinational. It looks at the current instruction word and takes the major opcode from bits 31:26 and the function code from bits 5:0. From these two fields it produces the full set of datapath steering signals:

- the register destination select and the writeback source select, each 2 bits wide;
- the ALU operand-B select;
- the register file write enable;
- the data memory read and write strobes;
- the three PC-redirect requests (branch, absolute jump, jump to register);
- a 2-bit ALU operation class, which a separate ALU-function decoder refines.

The destination and writeback selects are 2 bits wide so that a link address (PC+4) can be written back. For an absolute call it goes to register 31. For a register-indirect call it goes to rd. The two register-indirect jumps share the register-format opcode and are told apart by their function codes. Any select that an instruction does not need is driven to 0. The whole control vector is therefore fully defined for every input, and it can be compared bit for bit.

Top module: `mctl_main_dec`

## Requirements
- R1: Only instruction bits 31:26 (opcode) and 5:0 (function) affect the outputs; bits 25:6 have no effect.
- R2: Opcode 0x00 with function 0x20, 0x22, 0x24, 0x25 or 0x2A (register arithmetic) drives dst_sel=01, wb_sel=00, alu_src=0, reg_we=1, alu_cls=10, and all other outputs 0.
- R3: Opcode 0x00 with function 0x08 (jump to register) drives jump_reg=1 and every other output 0, including jump, branch, mem_we and reg_we.
- R4: Opcode 0x00 with function 0x09 (call through register) drives jump_reg=1, reg_we=1, dst_sel=01 (rd), wb_sel=10 (PC+4), and every other output 0.
- R5: Opcode 0x23 (load word) drives dst_sel=00 (rt), wb_sel=01 (memory data), alu_src=1, reg_we=1, mem_rd=1, alu_cls=00 (add), and every other output 0.
- R6: Opcode 0x2B (store word) drives alu_src=1, mem_we=1, alu_cls=00, and every other output 0.
- R7: Opcode 0x04 (branch if equal) drives branch=1, alu_src=0, alu_cls=01 (subtract), and every other output 0.
- R8: Opcode 0x02 (jump) drives jump=1 and every other output 0.
- R9: Opcode 0x03 (jump and link) drives jump=1, reg_we=1, dst_sel=10 (r31), wb_sel=10 (PC+4), and every other output 0.
- R10: Any other opcode, or opcode 0x00 with any other function code, drives every output to 0.
- R11: For every input, at most one of branch, jump and jump_reg is 1, and mem_rd and mem_we are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Current instruction word |
| dst_sel_o | output | 2 | Register destination select: 00 rt, 01 rd, 10 r31 |
| wb_sel_o | output | 2 | Writeback source: 00 ALU, 01 memory, 10 PC+4 |
| alu_src_o | output | 1 | ALU operand B: 0 register, 1 immediate |
| reg_we_o | output | 1 | Register file write enable |
| mem_rd_o | output | 1 | Data memory read strobe |
| mem_we_o | output | 1 | Data memory write strobe |
| branch_o | output | 1 | Conditional branch request |
| jump_o | output | 1 | Absolute jump request |
| jump_reg_o | output | 1 | Jump-to-register request |
| alu_cls_o | output | 2 | ALU class: 00 add, 01 subtract, 10 use function field |

## Verification
The bench targets the two register-indirect jumps:
- A decoder that looks only at the opcode would treat them as plain arithmetic and assert the ALU-class pattern, or would let the jump-to-register form write a register.
- A decoder that confuses the two link variants would send the register-indirect link to r31 instead of rd.

The bench also targets two kinds of illegal input:
- It drives undefined function codes under opcode 0.
- It drives opcodes next to the legal ones.
- A decoder with a loose default would then leave a write enable or a redirect asserted.

Finally, the bench randomizes bits 25:6 to catch field extraction taken from the wrong bit slice.

// File: rtl/mctl_pkg.sv
`timescale 1ns/1ps
package mctl_pkg;

   typedef enum logic [3:0] {
      K_ILLEGAL, K_RTYPE, K_JR, K_JALR, K_LOAD, K_STORE, K_BEQ, K_JUMP, K_JAL
   } kind_e;

   typedef enum logic [1:0] {DST_RT = 2'b00, DST_RD = 2'b01, DST_LINK = 2'b10} dst_e;
   typedef enum logic [1:0] {WB_ALU = 2'b00, WB_MEM = 2'b01, WB_PC4 = 2'b10} wb_e;
   typedef enum logic [1:0] {ALU_ADD = 2'b00, ALU_SUB = 2'b01, ALU_FUNCT = 2'b10} alucls_e;

   typedef struct packed {
      dst_e    dst;
      wb_e     wb;
      logic    alu_src;
      logic    reg_we;
      logic    mem_rd;
      logic    mem_we;
      logic    branch;
      logic    jump;
      logic    jump_reg;
      alucls_e alu;
   } ctrl_t;

   localparam ctrl_t CTRL_IDLE = '{dst: DST_RT, wb: WB_ALU, alu: ALU_ADD, default: 1'b0};

endpackage

// File: rtl/mctl_field_split.sv
`timescale 1ns/1ps
module mctl_field_split #(
   parameter int INSTR_W = 32,
   parameter int OP_LSB  = 26,
   parameter int OP_W    = 6,
   parameter int FN_LSB  = 0,
   parameter int FN_W    = 6
) (
   input  logic [INSTR_W-1:0] instr_i,
   output logic [OP_W-1:0]    op_o,
   output logic [FN_W-1:0]    fn_o
);
   localparam int OP_MSB = OP_LSB + OP_W - 1;
   localparam int FN_MSB = FN_LSB + FN_W - 1;

   generate
      if (OP_MSB >= INSTR_W || FN_MSB >= INSTR_W) begin : g_bad_width
         $error("mctl_field_split: field exceeds instruction width");
      end
      if (FN_MSB >= OP_LSB) begin : g_bad_overlap
         $error("mctl_field_split: function field overlaps opcode field");
      end
   endgenerate

   assign op_o = instr_i[OP_MSB:OP_LSB];
   assign fn_o = instr_i[FN_MSB:FN_LSB];

   // Operand bits are deliberately not consumed by this decoder.
   logic unused_operand_bits;
   assign unused_operand_bits = ^instr_i;
endmodule

// File: rtl/mctl_kind_dec.sv
`timescale 1ns/1ps
module mctl_kind_dec
   import mctl_pkg::*;
#(
   parameter int             OP_W       = 6,
   parameter int             FN_W       = 6,
   parameter logic [OP_W-1:0] OPC_SPECIAL = 6'h00,
   parameter logic [OP_W-1:0] OPC_LOAD    = 6'h23,
   parameter logic [OP_W-1:0] OPC_STORE   = 6'h2B,
   parameter logic [OP_W-1:0] OPC_BEQ     = 6'h04,
   parameter logic [OP_W-1:0] OPC_JUMP    = 6'h02,
   parameter logic [OP_W-1:0] OPC_JAL     = 6'h03,
   parameter logic [FN_W-1:0] FN_JR       = 6'h08,
   parameter logic [FN_W-1:0] FN_JALR     = 6'h09,
   parameter logic [FN_W-1:0] FN_ADD      = 6'h20,
   parameter logic [FN_W-1:0] FN_SUB      = 6'h22,
   parameter logic [FN_W-1:0] FN_AND      = 6'h24,
   parameter logic [FN_W-1:0] FN_OR       = 6'h25,
   parameter logic [FN_W-1:0] FN_SLT      = 6'h2A
) (
   input  logic [OP_W-1:0] op_i,
   input  logic [FN_W-1:0] fn_i,
   output kind_e           kind_o
);
   kind_e special_kind;

   // Register-format sub-decode driven purely by the function field.
   always_comb begin
      unique case (fn_i)
         FN_JR:                                  special_kind = K_JR;
         FN_JALR:                                special_kind = K_JALR;
         FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT:  special_kind = K_RTYPE;
         default:                                special_kind = K_ILLEGAL;
      endcase
   end

   always_comb begin
      unique case (op_i)
         OPC_SPECIAL: kind_o = special_kind;
         OPC_LOAD:    kind_o = K_LOAD;
         OPC_STORE:   kind_o = K_STORE;
         OPC_BEQ:     kind_o = K_BEQ;
         OPC_JUMP:    kind_o = K_JUMP;
         OPC_JAL:     kind_o = K_JAL;
         default:     kind_o = K_ILLEGAL;
      endcase
   end
endmodule

// File: rtl/mctl_vec_enc.sv
`timescale 1ns/1ps
module mctl_vec_enc
   import mctl_pkg::*;
(
   input  kind_e kind_i,
   output ctrl_t ctrl_o
);
   always_comb begin
      ctrl_o = CTRL_IDLE;
      unique case (kind_i)
         K_RTYPE: begin
            ctrl_o.dst    = DST_RD;
            ctrl_o.reg_we = 1'b1;
            ctrl_o.alu    = ALU_FUNCT;
         end
         K_JR: begin
            ctrl_o.jump_reg = 1'b1;
         end
         K_JALR: begin
            ctrl_o.dst      = DST_RD;
            ctrl_o.wb       = WB_PC4;
            ctrl_o.reg_we   = 1'b1;
            ctrl_o.jump_reg = 1'b1;
         end
         K_LOAD: begin
            ctrl_o.wb      = WB_MEM;
            ctrl_o.alu_src = 1'b1;
            ctrl_o.reg_we  = 1'b1;
            ctrl_o.mem_rd  = 1'b1;
         end
         K_STORE: begin
            ctrl_o.alu_src = 1'b1;
            ctrl_o.mem_we  = 1'b1;
         end
         K_BEQ: begin
            ctrl_o.branch = 1'b1;
            ctrl_o.alu    = ALU_SUB;
         end
         K_JUMP: begin
            ctrl_o.jump = 1'b1;
         end
         K_JAL: begin
            ctrl_o.dst    = DST_LINK;
            ctrl_o.wb     = WB_PC4;
            ctrl_o.reg_we = 1'b1;
            ctrl_o.jump   = 1'b1;
         end
         default: ctrl_o = CTRL_IDLE;
      endcase
   end
endmodule

// File: rtl/mctl_main_dec.sv
`timescale 1ns/1ps
module mctl_main_dec
   import mctl_pkg::*;
#(
   parameter int INSTR_W = 32,
   parameter int OP_LSB  = 26,
   parameter int OP_W    = 6,
   parameter int FN_W    = 6
) (
   input  logic [INSTR_W-1:0] instr_i,
   output logic [1:0]         dst_sel_o,
   output logic [1:0]         wb_sel_o,
   output logic               alu_src_o,
   output logic               reg_we_o,
   output logic               mem_rd_o,
   output logic               mem_we_o,
   output logic               branch_o,
   output logic               jump_o,
   output logic               jump_reg_o,
   output logic [1:0]         alu_cls_o
);
   localparam int FN_LSB = 0;

   logic [OP_W-1:0] op;
   logic [FN_W-1:0] fn;
   kind_e           kind;
   ctrl_t           ctrl;

   mctl_field_split #(
      .INSTR_W(INSTR_W), .OP_LSB(OP_LSB), .OP_W(OP_W), .FN_LSB(FN_LSB), .FN_W(FN_W)
   ) u_split (
      .instr_i(instr_i), .op_o(op), .fn_o(fn)
   );

   mctl_kind_dec #(.OP_W(OP_W), .FN_W(FN_W)) u_kind (
      .op_i(op), .fn_i(fn), .kind_o(kind)
   );

   mctl_vec_enc u_enc (.kind_i(kind), .ctrl_o(ctrl));

   assign dst_sel_o  = ctrl.dst;
   assign wb_sel_o   = ctrl.wb;
   assign alu_src_o  = ctrl.alu_src;
   assign reg_we_o   = ctrl.reg_we;
   assign mem_rd_o   = ctrl.mem_rd;
   assign mem_we_o   = ctrl.mem_we;
   assign branch_o   = ctrl.branch;
   assign jump_o     = ctrl.jump;
   assign jump_reg_o = ctrl.jump_reg;
   assign alu_cls_o  = ctrl.alu;

   // Cross-checks between the kind decoder and the vector encoder.
   always_comb begin
      p_redirect_onehot_r11: assert ($onehot0({branch_o, jump_o, jump_reg_o}))
         else $error("more than one PC redirect asserted");
      p_mem_excl_r11: assert (!(mem_rd_o && mem_we_o))
         else $error("memory read and write both asserted");
      p_illegal_quiet_r10: assert (kind != K_ILLEGAL ||
                                   !(reg_we_o || mem_we_o || mem_rd_o || branch_o || jump_o || jump_reg_o))
         else $error("illegal instruction left an enable asserted");
      p_link_target_r9: assert (dst_sel_o != 2'b10 || (wb_sel_o == 2'b10 && reg_we_o && jump_o))
         else $error("r31 destination without link writeback");
      p_jr_no_write_r3: assert (!(jump_reg_o && !reg_we_o) || (wb_sel_o == 2'b00 && dst_sel_o == 2'b00))
         else $error("plain register jump drives write selects");
      p_store_no_we_r6: assert (!mem_we_o || (!reg_we_o && alu_src_o))
         else $error("store with register write or register operand");
   end
endmodule

// File: tb/mctl_main_dec_bench.sv
`timescale 1ns/1ps
module mctl_main_dec_bench;
   localparam time TCLK = 8ns;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr = '0;
   logic [1:0]  dst_sel, wb_sel, alu_cls;
   logic        alu_src, reg_we, mem_rd, mem_we, branch, jump, jump_reg;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(TCLK/2) clk = ~clk;

   mctl_main_dec u_mctl_main_dec (
      .instr_i(instr), .dst_sel_o(dst_sel), .wb_sel_o(wb_sel), .alu_src_o(alu_src),
      .reg_we_o(reg_we), .mem_rd_o(mem_rd), .mem_we_o(mem_we), .branch_o(branch),
      .jump_o(jump), .jump_reg_o(jump_reg), .alu_cls_o(alu_cls)
   );

   // Vector order: {dst,wb,alu_src,reg_we,mem_rd,mem_we,branch,jump,jump_reg,alu}
   function automatic logic [12:0] expect_vec(input logic [31:0] i);
      logic [5:0] op = i[31:26];
      logic [5:0] fn = i[5:0];
      case (op)
         6'h00: case (fn)
            6'h20, 6'h22, 6'h24, 6'h25, 6'h2A: return {2'b01, 2'b00, 7'b0100000, 2'b10};
            6'h08: return {2'b00, 2'b00, 7'b0000001, 2'b00};
            6'h09: return {2'b01, 2'b10, 7'b0100001, 2'b00};
            default: return '0;
         endcase
         6'h23: return {2'b00, 2'b01, 7'b1110000, 2'b00};
         6'h2B: return {2'b00, 2'b00, 7'b1001000, 2'b00};
         6'h04: return {2'b00, 2'b00, 7'b0000100, 2'b01};
         6'h02: return {2'b00, 2'b00, 7'b0000010, 2'b00};
         6'h03: return {2'b10, 2'b10, 7'b0100010, 2'b00};
         default: return '0;
      endcase
   endfunction

   function automatic string req_of(input logic [31:0] i);
      case (i[31:26])
         6'h00: case (i[5:0])
            6'h20, 6'h22, 6'h24, 6'h25, 6'h2A: return "R2";
            6'h08: return "R3";
            6'h09: return "R4";
            default: return "R10";
         endcase
         6'h23: return "R5";
         6'h2B: return "R6";
         6'h04: return "R7";
         6'h02: return "R8";
         6'h03: return "R9";
         default: return "R10";
      endcase
   endfunction

   function automatic logic [12:0] got_vec();
      return {dst_sel, wb_sel, alu_src, reg_we, mem_rd, mem_we, branch, jump, jump_reg, alu_cls};
   endfunction

   task automatic apply_and_check(input logic [31:0] i, input string tag);
      logic [12:0] exp_v;
      logic [12:0] act_v;
      @(negedge clk);
      instr = i;
      #2;
      exp_v = expect_vec(i);
      act_v = got_vec();
      n_run++;
      if (act_v !== exp_v) begin
         n_fail++;
         $display("FAIL %s instr=%h actual=%b expected=%b", tag, i, act_v, exp_v);
      end
      n_run++;  // R11 structural property observed at the ports
      if ((32'(branch) + 32'(jump) + 32'(jump_reg)) > 1 || (mem_rd && mem_we)) begin
         n_fail++;
         $display("FAIL R11 instr=%h actual=%b expected=at most one redirect, no rd+we", i, act_v);
      end
   endtask

   initial begin
      #(TCLK * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [5:0] op_pool [10] = '{6'h00, 6'h23, 6'h2B, 6'h04, 6'h02, 6'h03, 6'h22, 6'h05, 6'h01, 6'h3F};
      logic [5:0] fn_pool [10] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A, 6'h08, 6'h09, 6'h0A, 6'h21, 6'h00};
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      // Reset-time value: all-zero word is an unsupported function code
      apply_and_check(32'h0000_0000, "R10 reset");
      rst = 1'b0;

      // Directed: each instruction kind
      apply_and_check(32'h0123_4020, "R2 add");
      apply_and_check(32'h0123_402A, "R2 slt");
      apply_and_check(32'h03E0_0008, "R3 jr");
      apply_and_check(32'h0220_F809, "R4 jalr");
      apply_and_check(32'h8C88_0004, "R5 lw");
      apply_and_check(32'hAC88_0004, "R6 sw");
      apply_and_check(32'h1109_FFFC, "R7 beq");
      apply_and_check(32'h0800_0010, "R8 j");
      apply_and_check(32'h0C00_0010, "R9 jal");
      // Corner: neighbours of legal codes
      apply_and_check(32'h0000_000A, "R10 fn 0x0A");
      apply_and_check(32'h0000_0021, "R10 fn 0x21");
      apply_and_check(32'h1400_0000, "R10 op 0x05");
      apply_and_check(32'h8000_0000, "R10 op 0x20");
      apply_and_check(32'hAC00_0008, "R6 store with fn 0x08");
      apply_and_check(32'h8C00_0009, "R5 load with fn 0x09");
      // R1: middle bits must not matter
      apply_and_check(32'h03FF_FFC8, "R1 jr middle ones");
      apply_and_check(32'h0FFF_FFC0, "R1 jal middle ones");
      apply_and_check(32'h03FF_FFC0, "R1 op0 fn0 middle ones");

      // Constrained random
      for (int k = 0; k < 4000; k++) begin
         logic [31:0] w = $urandom;
         if ($urandom_range(3) != 0) w[31:26] = op_pool[$urandom_range(9)];
         if ($urandom_range(3) != 0) w[5:0]   = fn_pool[$urandom_range(9)];
         apply_and_check(w, {req_of(w), " R1 random"});
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule